// File: doc/BRIEF.md
# Gardner Timing Error Detector

This block measures symbol-timing error for a QPSK receiver that samples its matched-filter outputs at two samples per symbol. Each rail (in-phase and quadrature) delivers an alternating stream of samples: one taken at the symbol instant, the next halfway to the following symbol. For every symbol sample the block forms the zero-crossing error, which is the mid-symbol sample multiplied by the change between the two symbol samples on either side of it. It adds the two rails' terms and sends out one signed 10-bit error word.

The error word is meant for a DAC that pulls the voltage-controlled crystal oscillator clocking the ADC. That ADC runs at four times the symbol rate. When the symbol samples land on the eye centres, the mid sample of a transition sits on the zero crossing and the error is zero. Sampling early gives a negative word and sampling late gives a positive one. An internal phase toggle tracks which incoming sample is a symbol sample. A marker input can force a sample to be taken as a symbol sample, which re-aligns the toggle.

Top module: `timing_error_detector`

## Requirements
- R1: For each symbol sample that produces an output, the word equals floor((Im·(In − Ip) + Qm·(Qn − Qp)) / 2^SHIFT), with SHIFT = 9 by default. In this formula n is the new symbol sample, p is the previous symbol sample and m is the mid sample taken between them, all signed two's complement.
- R2: The scaled value is clamped to the signed 10-bit range. Values above 511 give 511 and values below −512 give −512.
- R3: After reset the first valid sample is a symbol sample, and later valid samples alternate between mid and symbol samples. Cycles with `smp_valid` low change nothing.
- R4: A valid sample with `smp_sym_mark` high is a symbol sample. If that sample arrives when a mid sample was expected, it produces no output and becomes the previous symbol sample for the next error.
- R5: The symbol sample captured at clock edge k produces an output at edge k+1. `err_valid` stays high for exactly one cycle.
- R6: Mid samples never produce an output. No output appears until the second symbol sample after reset or after a resync.
- R7: While `rst` is high at a clock edge, the next cycle shows `err_valid` low and `err_word` equal to 0. History from before the reset never enters a later error.
- R8: For an alternating ±A symbol pattern, a zero mid sample gives an error of 0. A mid sample with the sign of the previous symbol (early sampling) gives a negative word. A mid sample with the sign of the new symbol (late sampling) gives a positive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe for smp_i and smp_q |
| smp_sym_mark | input | 1 | Forces this sample to be a symbol sample |
| smp_i | input | 10 | In-phase sample, signed |
| smp_q | input | 10 | Quadrature sample, signed |
| err_valid | output | 1 | One-cycle strobe for each error word |
| err_word | output | 10 | Signed timing error |

## Verification
Each error word appears one cycle after the clock edge that captures its symbol sample. The products are registered at the capture edge, and the sum and clamp are registered at the next edge. The bench drives each sample for a single edge, then waits one further edge and reads `err_valid` and `err_word` 1 ns after it. At the following edge it confirms the strobe has dropped. Mid samples, the first symbol after reset and resync samples all get the same edge-plus-one check, and there the bench expects the strobe to be low.

// File: rtl/ted_pkg.sv
package ted_pkg;
  localparam int NUM_RAILS = 2;
  localparam int RAIL_I    = 0;
  localparam int RAIL_Q    = 1;
endpackage

// File: rtl/ted_phase_track.sv
module ted_phase_track (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic sym_mark,
  output logic is_sym,
  output logic fire,
  output logic restart
);
  logic expect_sym_q;
  logic have_sym_q;

  assign is_sym  = expect_sym_q | sym_mark;
  assign restart = in_valid & sym_mark & ~expect_sym_q;
  assign fire    = in_valid & is_sym & have_sym_q & ~restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_sym_q <= 1'b1;
      have_sym_q   <= 1'b0;
    end else if (in_valid) begin
      expect_sym_q <= ~is_sym;
      if (is_sym) have_sym_q <= 1'b1;
    end
  end

  // After a resync, the history holds exactly one symbol and a mid sample is due next.
  assert_resync_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (have_sym_q && !expect_sym_q));
endmodule

// File: rtl/ted_rail.sv
module ted_rail #(
  parameter int SAMPLE_W = 10,
  parameter int PROD_W   = 2 * SAMPLE_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     is_sym,
  input  logic                     fire,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [PROD_W-1:0]   prod
);
  logic signed [SAMPLE_W-1:0] prev_sym_q;
  logic signed [SAMPLE_W-1:0] mid_q;
  logic signed [PROD_W-1:0]   mid_x;
  logic signed [PROD_W-1:0]   diff_x;
  logic signed [PROD_W-1:0]   prod_d;

  always_comb begin
    mid_x  = PROD_W'(mid_q);
    diff_x = PROD_W'(sample) - PROD_W'(prev_sym_q);
    prod_d = mid_x * diff_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sym_q <= '0;
      mid_q      <= '0;
      prod       <= '0;
    end else if (in_valid) begin
      if (is_sym) begin
        prev_sym_q <= sample;
        if (fire) prod <= prod_d;
      end else begin
        mid_q <= sample;
      end
    end
  end

  // A mid sample leaves the stored symbol untouched (R3 alternation bookkeeping).
  assert_mid_keeps_sym_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_sym) |=> $stable(prev_sym_q));
endmodule

// File: rtl/ted_combine.sv
module ted_combine #(
  parameter int PROD_W = 21,
  parameter int ERR_W  = 10,
  parameter int SHIFT  = 9,
  parameter int RAILS  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fire_in,
  input  logic [RAILS-1:0][PROD_W-1:0]  prods,
  output logic                          err_valid,
  output logic signed [ERR_W-1:0]       err_word
);
  localparam int SUM_W = PROD_W + $clog2(RAILS) + 1;
  localparam logic signed [SUM_W-1:0] ERR_MAX = SUM_W'((1 << (ERR_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] ERR_MIN = -ERR_MAX - 1;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] scaled;
  logic signed [ERR_W-1:0] clamped;

  always_comb begin
    sum = '0;
    for (int r = 0; r < RAILS; r++) begin
      sum = sum + SUM_W'($signed(prods[r]));
    end
    scaled = sum >>> SHIFT;
    if (scaled > ERR_MAX)      clamped = ERR_MAX[ERR_W-1:0];
    else if (scaled < ERR_MIN) clamped = ERR_MIN[ERR_W-1:0];
    else                       clamped = scaled[ERR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_word  <= '0;
    end else begin
      err_valid <= fire_in;
      if (fire_in) err_word <= clamped;
    end
  end

  // Clamping never flips the sign of the summed rail products.
  assert_sign_kept_R2: assert property (@(posedge clk) disable iff (rst)
    fire_in |=> (err_word[ERR_W-1] == $past(sum[SUM_W-1])));
endmodule

// File: rtl/timing_error_detector.sv
module timing_error_detector #(
  parameter int SAMPLE_W = 10,
  parameter int ERR_W    = 10,
  parameter int SHIFT    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic                smp_sym_mark,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] smp_q,
  output logic                err_valid,
  output logic [ERR_W-1:0]    err_word
);
  import ted_pkg::*;
  localparam int PROD_W = 2 * SAMPLE_W + 1;

  logic is_sym, fire, restart;
  logic fire_q;
  logic [NUM_RAILS-1:0][SAMPLE_W-1:0] rail_in;
  logic [NUM_RAILS-1:0][PROD_W-1:0]   rail_prod;
  logic signed [ERR_W-1:0]            err_s;

  assign rail_in[RAIL_I] = smp_i;
  assign rail_in[RAIL_Q] = smp_q;

  ted_phase_track u_phase (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .sym_mark(smp_sym_mark),
    .is_sym(is_sym), .fire(fire), .restart(restart)
  );

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic signed [PROD_W-1:0] p;
    ted_rail #(.SAMPLE_W(SAMPLE_W), .PROD_W(PROD_W)) u_rail (
      .clk(clk), .rst(rst), .in_valid(smp_valid), .is_sym(is_sym),
      .fire(fire), .sample($signed(rail_in[r])), .prod(p)
    );
    assign rail_prod[r] = p;
  end

  always_ff @(posedge clk) begin
    if (rst) fire_q <= 1'b0;
    else     fire_q <= fire;
  end

  ted_combine #(.PROD_W(PROD_W), .ERR_W(ERR_W), .SHIFT(SHIFT), .RAILS(NUM_RAILS)) u_comb (
    .clk(clk), .rst(rst), .fire_in(fire_q), .prods(rail_prod),
    .err_valid(err_valid), .err_word(err_s)
  );
  assign err_word = err_s;

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> (!err_valid && err_word == '0));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $past(smp_valid, 2));
  assert_restart_silent_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> ##1 !err_valid);
endmodule

// File: tb/timing_error_detector_test.sv
module timing_error_detector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic smp_sym_mark = 1'b0;
  logic [9:0] smp_i = '0;
  logic [9:0] smp_q = '0;
  logic err_valid;
  logic [9:0] err_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int prev_i, prev_q;

  always #2 clk = ~clk;

  timing_error_detector uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_sym_mark(smp_sym_mark),
    .smp_i(smp_i), .smp_q(smp_q), .err_valid(err_valid), .err_word(err_word)
  );

  // Vector: mid I, mid Q, symbol I, symbol Q, expected sign (-1, 0, +1, 2 = any)
  localparam int NV = 11;
  localparam int VEC [NV][5] = '{
    '{   0,    0, -200, -200,  0},
    '{   0,    0,  200,  200,  0},
    '{  60,   60, -200, -200, -1},
    '{ -60,  -60,  200,  200, -1},
    '{ -60,  -60, -200, -200,  1},
    '{  60,  -60, -200,  200, -1},
    '{ 511,  511, -512, -512,  2},
    '{ 100,  100, -512, -512,  0},
    '{-512, -512,  511,  511, -1},
    '{ 511,  511, -512, -512, -1},
    '{-512, -512,  511,  511, -1}
  };

  function automatic int model(int mi, int mq, int ni, int nq, int pi, int pq);
    longint s;
    longint sc;
    s  = longint'(mi) * (ni - pi) + longint'(mq) * (nq - pq);
    sc = s >>> 9;
    if (sc > 511)  sc = 511;
    if (sc < -512) sc = -512;
    return int'(sc);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one sample, then check the output one edge after capture and the drop of the strobe.
  task automatic push(int i, int q, bit mark, bit exp_v, int exp_val, string req);
    @(negedge clk);
    smp_valid = 1'b1; smp_sym_mark = mark;
    smp_i = 10'(i); smp_q = 10'(q);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0; smp_sym_mark = 1'b0;
    @(posedge clk); #1;
    check(err_valid == exp_v, req, int'(err_valid), int'(exp_v));
    if (exp_v)
      check($signed(err_word) == exp_val, req, int'($signed(err_word)), exp_val);
    @(posedge clk); #1;
    check(err_valid == 1'b0, "R5 pulse", int'(err_valid), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(err_valid == 1'b0 && err_word == '0, "R7 reset state", int'(err_valid), 0);
    @(negedge clk); rst = 1'b0;

    // R6: first symbol and a mid give nothing
    push(200, 200, 1'b0, 1'b0, 0, "R6 first symbol");
    prev_i = 200; prev_q = 200;

    // Table walk: R1, R2, R8
    for (int v = 0; v < NV; v++) begin
      int e;
      e = model(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], prev_i, prev_q);
      push(VEC[v][0], VEC[v][1], 1'b0, 1'b0, 0, "R6 mid no output");
      push(VEC[v][2], VEC[v][3], 1'b0, 1'b1, e, "R1 error value");
      if (VEC[v][4] == -1) check($signed(err_word) < 0, "R8 early negative", int'($signed(err_word)), -1);
      if (VEC[v][4] ==  1) check($signed(err_word) > 0, "R8 late positive", int'($signed(err_word)), 1);
      if (VEC[v][4] ==  0) check(err_word == '0, "R8 aligned zero", int'($signed(err_word)), 0);
      if (v >= 8) check($signed(err_word) == 511 || $signed(err_word) == -512,
                        "R2 clamp", int'($signed(err_word)), e);
      prev_i = VEC[v][2]; prev_q = VEC[v][3];
    end

    // R3: idle gaps between samples do not disturb the alternation
    repeat (5) @(posedge clk);
    push(0, 0, 1'b0, 1'b0, 0, "R3 mid after gap");
    repeat (7) @(posedge clk);
    push(-300, 100, 1'b0, 1'b1, 0, "R3 symbol after gap");
    prev_i = -300; prev_q = 100;

    // R4: marked sample while a mid is due restarts history
    push(250, -250, 1'b1, 1'b0, 0, "R4 resync silent");
    push(40, 40, 1'b0, 1'b0, 0, "R4 mid after resync");
    push(-250, 250, 1'b0, 1'b1, model(40, 40, -250, 250, 250, -250), "R4 resync prev");
    // R4: mark on an expected symbol behaves normally
    push(-30, 30, 1'b0, 1'b0, 0, "R4 mid");
    push(250, -250, 1'b1, 1'b1, model(-30, 30, 250, -250, -250, 250), "R4 marked symbol");

    // R7: reset mid-stream discards history
    do_reset();
    #1;
    check(err_valid == 1'b0 && err_word == '0, "R7 after reset", int'($signed(err_word)), 0);
    push(100, 100, 1'b0, 1'b0, 0, "R7 first is symbol");
    push(-20, 20, 1'b0, 1'b0, 0, "R7 mid");
    push(-100, -100, 1'b0, 1'b1, model(-20, 20, -100, -100, 100, 100), "R7 fresh history");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule